// File: doc/BRIEF.md
# Stepped Soft-Start Sequencer

This block paces the startup of a switching converter. When the supply has crossed its turn-on level, a start request launches a staircase: a level code climbs from 0 to 31, one step per fixed interval of clock cycles. Alongside the code, the block drives a word of binary-weighted current-sink enables whose value falls by one weight unit at every step. A falling sink current lets the permitted duty cycle rise gradually. After the last interval every sink weight is switched off and a done flag is raised. The done flag is the signal that allows frequency jitter and lets the overload blanking timer run.

An abort, issued when the supply drops below its turn-off level, returns the sequencer to idle from any state and clears the level. Every startup, including each automatic restart attempt, therefore begins again at level zero. While the staircase runs or after it has finished, further start requests have no effect. Only a start from idle launches a new run.

Top module: `ss_softstart_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `step_o` is 0, `sink_en_o` is 0 and `done_o` is 0.
- R2: A start sampled in idle without abort gives, one clock later, `step_o` = 0 and `sink_en_o` = all ones (63 with the defaults). Bit i of `sink_en_o` enables the sink weight 2^i·I.
- R3: During the ramp, `step_o` rises by exactly one every `STEP_CYC` clocks. Level k is first visible `k·STEP_CYC` clocks after the start edge, and `step_o` never skips or falls back except on abort.
- R4: During the ramp, `sink_en_o` equals (2^(LVL_W+1) − 1) − `step_o`, so the sink word falls by one at each step, keeps its top bit set, and changes only on a step boundary, a start or an abort.
- R5: `NUM_STEPS·STEP_CYC` clocks after the start edge, `done_o` goes to 1, `sink_en_o` becomes 0 and `step_o` holds at `NUM_STEPS`−1. `done_o` is never 1 while any sink bit is set.
- R6: A start while ramping or done is ignored: level, sink word and done flag continue as if it were absent.
- R7: An abort returns the block to idle one clock later (`step_o` 0, `sink_en_o` 0, `done_o` 0), taking precedence over a start or a step boundary in the same cycle.
- R8: A start after an abort begins a fresh ramp from level 0, with the full interval before level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Supply has crossed the turn-on level; launches a ramp from idle |
| abort_i | input | 1 | Supply is below the turn-off level; forces idle |
| step_o | output | LVL_W (5) | Current staircase level |
| sink_en_o | output | LVL_W+1 (6) | Binary-weighted sink enables, bit i = weight 2^i |
| done_o | output | 1 | Ramp complete; enables jitter and overload blanking |

## Verification
An abort can coincide with a start request or with the last cycle of a step interval, and the abort has to win both races. The bench provokes the first case with a combined abort and start in idle. It provokes the second by timing an abort onto the exact cycle where the interval counter would roll over. In each case it checks that the block is idle one clock later with a zero sink word. Random stimulus with a low abort rate and a higher start rate produces further collisions, including starts during ramp and done. A bench-side state model, built from the requirements, judges every cycle.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [1:0] {
    SS_IDLE = 2'd0,
    SS_RAMP = 2'd1,
    SS_DONE = 2'd2
  } ss_state_e;

  // Sink word for a level: all weights on at level 0, one unit less per step.
  function automatic logic [15:0] ramp_sink(input int unsigned lvl, input int unsigned lvl_w);
    int unsigned full;
    full = (32'd1 << (lvl_w + 1)) - 32'd1;
    return 16'(full - lvl);
  endfunction

endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int unsigned STEP_CYC = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  localparam int unsigned CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (enable)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign tick = enable && (cnt_q == LAST);

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_cnt_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/ss_level_ctr.sv
module ss_level_ctr #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [LVL_W-1:0] level,
  output logic             at_top
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               level <= '0;
    else if (clear)           level <= '0;
    else if (inc && !at_top)  level <= level + LVL_W'(1);
  end

  assign at_top = (level == '1);

  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && inc && !at_top) |=> (level == $past(level) + LVL_W'(1)));

  assert_level_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !inc) |=> $stable(level));

endmodule

// File: rtl/ss_sink_reg.sv
module ss_sink_reg #(
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned SINK_W = LVL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_on,
  input  logic [LVL_W-1:0]  next_level,
  output logic [SINK_W-1:0] sink
);
  import ss_pkg::*;

  logic [15:0]       sink_full;
  logic [SINK_W-1:0] sink_d;

  always_comb begin
    sink_full = ramp_sink(int'(next_level), LVL_W);
    sink_d    = ramp_on ? sink_full[SINK_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sink <= '0;
    else        sink <= sink_d;
  end

endmodule

// File: rtl/ss_softstart_seq.sv
module ss_softstart_seq #(
  parameter int unsigned STEP_CYC  = 30000,
  parameter int unsigned NUM_STEPS = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           abort_i,
  output logic [$clog2(NUM_STEPS)-1:0]   step_o,
  output logic [$clog2(NUM_STEPS):0]     sink_en_o,
  output logic                           done_o
);
  import ss_pkg::*;

  localparam int unsigned LVL_W  = $clog2(NUM_STEPS);
  localparam int unsigned SINK_W = LVL_W + 1;

  ss_state_e        state_q, state_d;
  logic             go_w, clr_w, tick_w, step_w, finish_w, at_top_w;
  logic [LVL_W-1:0] level_w, next_level_w;

  // Named events
  assign go_w     = (state_q == SS_IDLE) && start_i && !abort_i;
  assign clr_w    = abort_i || go_w;
  assign step_w   = tick_w && !at_top_w && !abort_i;
  assign finish_w = tick_w && at_top_w && !abort_i;

  ss_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clr_w),
    .enable (state_q == SS_RAMP),
    .tick   (tick_w)
  );

  ss_level_ctr #(.LVL_W(LVL_W)) u_level (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clr_w),
    .inc    (step_w),
    .level  (level_w),
    .at_top (at_top_w)
  );

  always_comb begin
    state_d = state_q;
    if (abort_i)       state_d = SS_IDLE;
    else if (go_w)     state_d = SS_RAMP;
    else if (finish_w) state_d = SS_DONE;
  end

  always_comb begin
    if (clr_w)       next_level_w = '0;
    else if (step_w) next_level_w = level_w + LVL_W'(1);
    else             next_level_w = level_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SS_IDLE;
    else        state_q <= state_d;
  end

  ss_sink_reg #(.LVL_W(LVL_W), .SINK_W(SINK_W)) u_sink (
    .clk        (clk),
    .rst_n      (rst_n),
    .ramp_on    (state_d == SS_RAMP),
    .next_level (next_level_w),
    .sink       (sink_en_o)
  );

  assign step_o = level_w;
  assign done_o = (state_q == SS_DONE);

  assert_done_sink_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sink_en_o == '0));

  assert_done_from_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(step_o) == '1));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!done_o && step_o == '0 && sink_en_o == '0));

  assert_sink_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sink_en_o) |-> $past(tick_w || go_w || abort_i));

  assert_ramp_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SS_RAMP) |-> sink_en_o[SINK_W-1]);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && !abort_i) |=> done_o);

endmodule

// File: tb/ss_softstart_seq_tb.sv
module ss_softstart_seq_tb;
  localparam int STEP = 5;
  localparam int NS   = 32;
  localparam int LW   = 5;
  localparam int SW   = 6;

  logic          clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0;
  logic [LW-1:0] step_o;
  logic [SW-1:0] sink_en_o;
  logic          done_o;

  int n_tests = 0, n_fail = 0;
  int m_st = 0, m_cnt = 0, m_lvl = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ss_softstart_seq #(.STEP_CYC(STEP), .NUM_STEPS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .step_o(step_o), .sink_en_o(sink_en_o), .done_o(done_o)
  );

  function automatic int exp_sink(input int st, input int lvl);
    if (st == 1) return (2 ** SW - 1) - lvl;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    check({tag, " level R3"}, int'(step_o), m_lvl);
    check({tag, " sink R4"}, int'(sink_en_o), exp_sink(m_st, m_lvl));
    check({tag, " done R5"}, int'(done_o), (m_st == 2) ? 1 : 0);
  endtask

  // One clock: drive, update the model at the edge, settle at the falling edge.
  task automatic cyc(input logic a, input logic s);
    abort_i = a; start_i = s;
    @(posedge clk);
    if (a) begin m_st = 0; m_lvl = 0; m_cnt = 0; end
    else if (m_st == 0 && s) begin m_st = 1; m_lvl = 0; m_cnt = 0; end
    else if (m_st == 1) begin
      if (m_cnt == STEP - 1) begin
        m_cnt = 0;
        if (m_lvl == NS - 1) m_st = 2; else m_lvl++;
      end else m_cnt++;
    end
    @(negedge clk);
    abort_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 reset level", int'(step_o), 0);
    check("R1 reset sink", int'(sink_en_o), 0);
    check("R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    cyc(0, 0);
    cmp_all("R1 after reset");

    // R2: launch
    cyc(0, 1);
    check("R2 start level", int'(step_o), 0);
    check("R2 start sink", int'(sink_en_o), 63);
    repeat (STEP - 1) cyc(0, 0);
    check("R3 level before first boundary", int'(step_o), 0);
    cyc(0, 0);
    check("R3 level at first boundary", int'(step_o), 1);
    check("R4 sink at first boundary", int'(sink_en_o), 62);
    for (int k = 2; k < NS; k++) begin
      repeat (STEP) cyc(0, 0);
      check("R3 staircase level", int'(step_o), k);
      check("R4 staircase sink", int'(sink_en_o), 63 - k);
    end
    check("R5 not yet done", int'(done_o), 0);
    repeat (STEP) cyc(0, 0);
    check("R5 done raised", int'(done_o), 1);
    check("R5 sink off", int'(sink_en_o), 0);
    check("R5 level held", int'(step_o), NS - 1);

    // R6: start while done
    cyc(0, 1);
    repeat (10) cyc(0, 0);
    check("R6 done kept", int'(done_o), 1);
    check("R6 level kept", int'(step_o), NS - 1);

    // R7: abort from done, then abort racing start
    cyc(1, 0);
    cmp_all("R7 abort from done");
    check("R7 abort level", int'(step_o), 0);
    cyc(1, 1);
    check("R7 abort beats start sink", int'(sink_en_o), 0);
    cyc(0, 0);
    check("R7 still idle", int'(sink_en_o), 0);

    // R6: start during ramp
    cyc(0, 1);
    repeat (3 * STEP) cyc(0, 0);
    cyc(0, 1);
    cmp_all("R6 start in ramp");
    repeat (STEP) cyc(0, 0);
    cmp_all("R6 after start in ramp");

    // R7: abort on the cycle of a step boundary
    while (m_cnt != STEP - 1) cyc(0, 0);
    cyc(1, 0);
    check("R7 abort at boundary level", int'(step_o), 0);
    check("R7 abort at boundary sink", int'(sink_en_o), 0);

    // R8: restart
    cyc(0, 1);
    check("R8 restart level", int'(step_o), 0);
    check("R8 restart sink", int'(sink_en_o), 63);
    repeat (STEP - 1) cyc(0, 0);
    check("R8 full first interval", int'(step_o), 0);
    cyc(0, 0);
    check("R8 level one", int'(step_o), 1);

    // Random mix judged by the model
    for (int i = 0; i < 6000; i++) begin
      logic a, s;
      a = (($urandom % 100) < 2);
      s = (($urandom % 100) < 15);
      cyc(a, s);
      cmp_all(a ? "R7 random abort" : "R6 random");
    end

    summary();
  end
endmodule